// File: doc/BRIEF.md
# Leading Zero Count Unit

This block counts the zero bits that sit above the highest set bit of an integer operand, for use as one functional unit in an integer execution pipeline. It has two modes. In count mode it returns that number of zeros. In reverse scan mode it returns the bit position of the highest set bit. Each mode sets a carry flag and a zero flag by its own rules. The other condition flags are held at zero. The operand width is a parameter and is meant to be 32 or 64.

Count mode never reads the prior destination value, so it adds no false dependency to the datapath around it. Reverse scan mode does read that value, but only for an all-zero operand. In that case the prior value passes through unchanged, which gives a fixed and testable result. A valid strobe captures the operand, the mode and the prior value. The result, the flags and a result-valid signal appear on the registered outputs one cycle later. The count itself comes from a log-depth tree of 4-bit encoders and merge stages.

Top module: `lzc_unit`

## Requirements
- R1: Count mode (modeSel = 0) with a nonzero operand gives a result equal to the number of zero bits above the highest set bit.
- R2: Count mode with an all-zero operand gives a result equal to WIDTH.
- R3: In count mode carryOut is 1 exactly when the operand is all zeros.
- R4: In count mode zeroOut is 1 exactly when the count is zero, that is, when operand bit WIDTH-1 is 1.
- R5: Reverse scan mode (modeSel = 1) with a nonzero operand gives the index of the highest set bit, which equals WIDTH-1 minus the leading-zero count. In this case zeroOut is 0 and carryOut is 0.
- R6: Reverse scan mode with an all-zero operand sets zeroOut to 1, clears carryOut, and returns priorDst unchanged as the result.
- R7: The count mode result and flags do not depend on priorDst.
- R8: resultOut, carryOut and zeroOut take their new values on the clock edge that samples validIn = 1. validOut is 1 in exactly the cycle after each strobe. Reset clears validOut, resultOut and both flags.
- R9: otherFlags is always 0.
- R10: While validIn is 0, resultOut, carryOut and zeroOut hold their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Strobe that captures operand, mode and prior value |
| modeSel | input | 1 | 0 selects count mode, 1 selects reverse scan mode |
| operand | input | WIDTH | Value to be examined |
| priorDst | input | WIDTH | Prior destination value, used only for a zero operand in scan mode |
| resultOut | output | WIDTH | Registered count or bit index |
| carryOut | output | 1 | Registered carry flag |
| zeroOut | output | 1 | Registered zero flag |
| otherFlags | output | 4 | Remaining condition flags, held at zero |
| validOut | output | 1 | Result valid, one cycle after validIn |

## Verification
The properties assume that modeSel, operand and priorDst are stable and known in every cycle where validIn is 1. They relate those sampled values to the registered outputs one edge later, and they make no assumption about the inputs in idle cycles. The stimulus changes all inputs only on falling clock edges. It also loads deliberately different data into operand and priorDst during idle cycles, so the hold property sees real disturbance. The sweep sets the highest set bit at every position of a 32-bit operand, with varied lower bits and varied prior values, and it covers the all-zero and all-ones operands in both modes.

// File: rtl/lzc_pkg.sv
package lzc_pkg;

  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_SCAN  = 1'b1
  } lzc_mode_e;

  // strobes sent from control to datapath
  typedef struct packed {
    logic load;   // capture a new result this edge
    logic scan;   // captured op is a reverse scan
  } lzc_strobe_s;

  localparam int OTHER_FLAG_W = 4;

endpackage

// File: rtl/lzc_tree.sv
module lzc_tree #(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] operand,
  output logic [CW-1:0]    count
);
  localparam int LEAVES = WIDTH / 4;
  localparam int LEVELS = $clog2(LEAVES) + 1;

  function automatic logic [2:0] nibbleLz(input logic [3:0] n);
    casez (n)
      4'b1???: nibbleLz = 3'd0;
      4'b01??: nibbleLz = 3'd1;
      4'b001?: nibbleLz = 3'd2;
      4'b0001: nibbleLz = 3'd3;
      default: nibbleLz = 3'd4;
    endcase
  endfunction

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int NN = LEAVES >> lv;
    logic [CW-1:0] cnt [NN];
    if (lv == 0) begin : g_leaf
      for (genvar k = 0; k < NN; k++) begin : g_nib
        // node k covers the k-th nibble from the top
        assign cnt[k] = {{(CW-3){1'b0}}, nibbleLz(operand[WIDTH-1-4*k -: 4])};
      end
    end else begin : g_merge
      localparam int HALF = 2 << lv;   // span of each child
      for (genvar k = 0; k < NN; k++) begin : g_node
        logic [CW-1:0] upCnt;
        logic [CW-1:0] loCnt;
        assign upCnt = g_lvl[lv-1].cnt[2*k];
        assign loCnt = g_lvl[lv-1].cnt[2*k+1];
        assign cnt[k] = (upCnt == CW'(HALF)) ? (CW'(HALF) + loCnt) : upCnt;
      end
    end
  end

  assign count = g_lvl[LEVELS-1].cnt[0];

endmodule

// File: rtl/lzc_ctrl.sv
module lzc_ctrl
  import lzc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic        modeSel,
  output lzc_strobe_s strobe,
  output logic        validOut
);
  lzc_mode_e curMode;

  assign curMode     = lzc_mode_e'(modeSel);
  assign strobe.load = validIn;
  assign strobe.scan = (curMode == MODE_SCAN);

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

endmodule

// File: rtl/lzc_datapath.sv
module lzc_datapath
  import lzc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  lzc_strobe_s      strobe,
  input  logic [WIDTH-1:0] operand,
  input  logic [WIDTH-1:0] priorDst,
  output logic [WIDTH-1:0] resultOut,
  output logic             carryOut,
  output logic             zeroOut
);
  localparam int CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(WIDTH);
  localparam logic [CW-1:0] TOP_IDX  = CW'(WIDTH - 1);

  logic [CW-1:0]    lzCount;
  logic             isZero;
  logic [CW-1:0]    msbIdx;
  logic [WIDTH-1:0] nextResult;
  logic             nextCarry;
  logic             nextZero;

  lzc_tree #(.WIDTH(WIDTH)) u_tree (
    .operand (operand),
    .count   (lzCount)
  );

  assign isZero = (lzCount == FULL_CNT);
  assign msbIdx = TOP_IDX - lzCount;

  always_comb begin
    if (strobe.scan) begin
      nextResult = isZero ? priorDst : WIDTH'(msbIdx);
      nextCarry  = 1'b0;
      nextZero   = isZero;
    end else begin
      nextResult = WIDTH'(lzCount);
      nextCarry  = isZero;
      nextZero   = (lzCount == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut <= '0;
      carryOut  <= 1'b0;
      zeroOut   <= 1'b0;
    end else if (strobe.load) begin
      resultOut <= nextResult;
      carryOut  <= nextCarry;
      zeroOut   <= nextZero;
    end
  end

endmodule

// File: rtl/lzc_unit.sv
module lzc_unit
  import lzc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    validIn,
  input  logic                    modeSel,
  input  logic [WIDTH-1:0]        operand,
  input  logic [WIDTH-1:0]        priorDst,
  output logic [WIDTH-1:0]        resultOut,
  output logic                    carryOut,
  output logic                    zeroOut,
  output logic [OTHER_FLAG_W-1:0] otherFlags,
  output logic                    validOut
);
  lzc_strobe_s strobe;

  lzc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .modeSel  (modeSel),
    .strobe   (strobe),
    .validOut (validOut)
  );

  lzc_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .operand   (operand),
    .priorDst  (priorDst),
    .resultOut (resultOut),
    .carryOut  (carryOut),
    .zeroOut   (zeroOut)
  );

  // R9: remaining flags are tied low
  assign otherFlags = '0;

endmodule

// File: rtl/lzc_unit_chk.sv
module lzc_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             validIn,
  input logic             modeSel,
  input logic [WIDTH-1:0] operand,
  input logic [WIDTH-1:0] priorDst,
  input logic [WIDTH-1:0] resultOut,
  input logic             carryOut,
  input logic             zeroOut,
  input logic             validOut
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);

  a_r2_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !modeSel && operand == '0) |=> (resultOut == WIDTH'(WIDTH)));

  a_r3_carry_count: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !modeSel) |=> (carryOut == ($past(operand) == '0)));

  a_r4_zero_flag_count: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !modeSel) |=> (zeroOut == $past(operand[WIDTH-1])));

  a_r5_scan_index: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && modeSel && operand != '0) |=>
      (!zeroOut && !carryOut && (($past(operand) >> resultOut) == WIDTH'(1))));

  a_r6_scan_zero: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && modeSel && operand == '0) |=>
      (zeroOut && !carryOut && resultOut == $past(priorDst)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(resultOut) && $stable(carryOut) && $stable(zeroOut)));

endmodule

bind lzc_unit lzc_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_lzc_unit.sv
module test_lzc_unit;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0;
  logic         modeSel = 1'b0;
  logic [W-1:0] operand = '0;
  logic [W-1:0] priorDst = '0;
  logic [W-1:0] resultOut;
  logic         carryOut;
  logic         zeroOut;
  logic [3:0]   otherFlags;
  logic         validOut;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lzc_unit #(.WIDTH(W)) i_lzc_unit (
    .clk        (clk),
    .rstN       (rstN),
    .validIn    (validIn),
    .modeSel    (modeSel),
    .operand    (operand),
    .priorDst   (priorDst),
    .resultOut  (resultOut),
    .carryOut   (carryOut),
    .zeroOut    (zeroOut),
    .otherFlags (otherFlags),
    .validOut   (validOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int refLz(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--)
      if (v[i]) return W - 1 - i;
    return W;
  endfunction

  task automatic run(input logic [W-1:0] op, input logic mode, input logic [W-1:0] prior,
                     input string tag);
    int lz;
    logic [W-1:0] expRes;
    logic expC;
    logic expZ;
    @(negedge clk);
    operand = op; modeSel = mode; priorDst = prior; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0; operand = ~op; priorDst = ~prior; modeSel = ~mode;
    lz = refLz(op);
    if (!mode) begin
      expRes = W'(lz); expC = (op == '0); expZ = (lz == 0);
      check({tag, (op == '0) ? " R2" : " R1"}, 64'(resultOut), 64'(expRes));
      check({tag, " R3"}, 64'(carryOut), 64'(expC));
      check({tag, " R4"}, 64'(zeroOut), 64'(expZ));
    end else begin
      expRes = (op == '0) ? prior : W'(W - 1 - lz);
      expC = 1'b0; expZ = (op == '0);
      check({tag, (op == '0) ? " R6" : " R5"}, 64'(resultOut), 64'(expRes));
      check({tag, (op == '0) ? " R6 carry" : " R5 carry"}, 64'(carryOut), 64'(expC));
      check({tag, (op == '0) ? " R6 zero" : " R5 zero"}, 64'(zeroOut), 64'(expZ));
    end
    check({tag, " R8 valid"}, 64'(validOut), 64'd1);
    check({tag, " R9"}, 64'(otherFlags), 64'd0);
    @(negedge clk);
    check({tag, " R10 result"}, 64'(resultOut), 64'(expRes));
    check({tag, " R10 flags"}, 64'({carryOut, zeroOut}), 64'({expC, expZ}));
    check({tag, " R8 idle"}, 64'(validOut), 64'd0);
  endtask

  initial begin
    logic [W-1:0] op;
    logic [W-1:0] lowMask;
    logic [W-1:0] resA;
    repeat (3) @(negedge clk);
    check("R8 reset valid", 64'(validOut), 64'd0);
    check("R8 reset result", 64'(resultOut), 64'd0);
    check("R8 reset flags", 64'({carryOut, zeroOut}), 64'd0);
    check("R9 reset", 64'(otherFlags), 64'd0);
    rstN = 1'b1;

    run('0, 1'b0, 32'h1234_5678, "zero count");
    run('0, 1'b1, 32'hCAFE_F00D, "zero scan");
    run('1, 1'b0, 32'h0, "ones count");
    run('1, 1'b1, 32'h0, "ones scan");

    for (int pos = 0; pos < W; pos++) begin
      lowMask = (W'(1) << pos) - W'(1);
      for (int p = 0; p < 8; p++) begin
        op = (W'(1) << pos) | (W'($urandom) & lowMask);
        if (p == 0) op = W'(1) << pos;
        if (p == 1) op = (W'(1) << pos) | lowMask;
        run(op, 1'b0, W'($urandom), "sweep count");
        run(op, 1'b1, W'($urandom), "sweep scan");
      end
    end

    // R7: same operand, opposite prior values
    for (int pos = 0; pos < W; pos += 5) begin
      op = (W'(1) << pos) | W'(pos);
      run(op, 1'b0, '0, "R7 prior low");
      resA = resultOut;
      run(op, 1'b0, '1, "R7 prior high");
      check("R7 prior independent", 64'(resultOut), 64'(resA));
    end

    // R6 with several prior values
    run('0, 1'b1, '0, "scan zero prior");
    run('0, 1'b1, '1, "scan zero prior");
    run('0, 1'b1, 32'hA5A5_0F0F, "scan zero prior");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule